// File: doc/BRIEF.md
# SYSREF Pulse Generator

This block produces a single-bit SYSREF timing signal from its clock. A small
pre-divider stretches every step of a programmable main divider, and the
divider waveform drives the output in one of three ways. It can run freely,
or it can release a counted burst of periods that starts on a request edge. A
third option ignores the divider and turns each request edge into one
single-clock pulse. The request input is a level that has already been
synchronised and qualified upstream. The block looks for its rising edges
itself.

Configuration is applied as static fields: enable, mode, pre-divide code,
divide value and pulse count. A busy flag is high while a burst is in
progress. An error flag reports that the block is enabled with a code it
does not support. In that case the output is held low.

Top module: `sysref_gen`

## Requirements
- R1: While `rst_n` is sampled low on a rising clock edge, `sysref_o`, `busy_o` and `cfg_err_o` are 0 after that edge.
- R2: The pre-divide code `cfg_prediv` selects a step length P of 1 (code 0), 2 (code 1) or 4 (code 2) clocks. Each divider phase lasts P clocks.
- R3: With mode code 0 (free-running), let t count the clocks after the first edge at which the block is enabled with valid codes, starting at t=0. Then `sysref_o` = 1 exactly when (t mod D·P) < floor(D/2)·P. D is `cfg_div`. An odd D therefore gives a high time below half the period.
- R4: Divide values across the full range 2 to 4095 follow R3. D=2 and D=4095 are the boundary cases.
- R5: With mode code 1 (burst), a rising request edge starts the burst. A rising edge means `req_i` was low at the previous edge and is high at this one, and the block must be idle. The divider restarts from phase zero on that edge. For t counted from the edge, `sysref_o` follows the R3 waveform while t < N·D·P, where N is `cfg_pulses` (1 to 15). `busy_o` is 1 for exactly those N·D·P clocks, and both are 0 afterwards.
- R6: A rising request edge that occurs while `busy_o` is 1 has no effect on the burst waveform or its length.
- R7: With mode code 2 (repeater), each rising request edge gives `sysref_o` = 1 for exactly the one clock after that edge. No other clock gives a 1, and `busy_o` stays 0.
- R8: While `cfg_en` is 1, the following codes are reserved: mode code 3, pre-divide code 3, `cfg_div` below 2, and `cfg_pulses` = 0 in burst mode. With a reserved code present, `sysref_o` is 0 and `busy_o` is 0, and `cfg_err_o` is 1 after the next edge. With `cfg_en` at 0, `cfg_err_o` is 0.
- R9: After an edge at which `cfg_en` is 0, `sysref_o` and `busy_o` are 0 and any burst is abandoned. A later enable restarts the waveform from phase zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Subsystem enable |
| cfg_mode | input | 2 | 0 free-running, 1 burst, 2 repeater, 3 reserved |
| cfg_prediv | input | 2 | Pre-divide code: 0 /1, 1 /2, 2 /4, 3 reserved |
| cfg_div | input | 12 | Main divide value, 2..4095 |
| cfg_pulses | input | 4 | Burst length in periods, 1..15 |
| req_i | input | 1 | Qualified request level |
| sysref_o | output | 1 | SYSREF output |
| busy_o | output | 1 | Burst in progress |
| cfg_err_o | output | 1 | Enabled with a reserved code |

## Verification
The hardest situation to reach is a second request edge that lands inside a running burst. The burst has to be long enough to leave room for it, and the edge has to fall on a chosen cycle. The bench drops the request a few clocks after the start and raises it again at a known offset while the burst is still running. It then checks that the waveform and the busy span match the undisturbed burst clock for clock. The longest burst (15 periods) and the largest divider (4095) are also run to their ends, so the wrap and terminal-count boundaries are covered.

// File: rtl/sysref_pkg.sv
// Shared types and sizes for the SYSREF pulse generator.
// Assumes a single clock domain; all config fields are quasi-static.
package sysref_pkg;
    localparam int DIV_W  = 12;   // main divider width
    localparam int PLS_W  = 4;    // pulse count width
    localparam int PRE_W  = 2;    // pre-divide code width
    localparam int PCNT_W = 2;    // pre-divide counter width (max /4)

    typedef enum logic [1:0] {
        MODE_FREE   = 2'd0,
        MODE_BURST  = 2'd1,
        MODE_REPEAT = 2'd2,
        MODE_RSVD   = 2'd3
    } mode_e;
endpackage

// File: rtl/sysref_prediv.sv
// Pre-divider: emits one step tick every 1, 2 or 4 clocks while advancing.
// Assumes code 3 never reaches it while advancing (top treats it as reserved).
module sysref_prediv
    import sysref_pkg::*;
#(
    parameter int CODE_W = PRE_W,
    parameter int CNT_W  = PCNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              adv_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              tick_o
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    // Purpose: terminal count for the selected step length.
    always_comb begin
        case (code_i)
            2'd0:    lim = CNT_W'(0);
            2'd1:    lim = CNT_W'(1);
            default: lim = CNT_W'(3);
        endcase
    end

    assign tick_o = adv_i && (cnt == lim);

    // Purpose: step counter, restarted by clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt <= '0;
        end else if (adv_i) begin
            cnt <= tick_o ? '0 : cnt + 1'b1;
        end
    end

    AST_PRE_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt == '0)); // R2
endmodule

// File: rtl/sysref_divider.sv
// Main divider: phase counter 0..div-1 advanced by pre-divider ticks.
// High phase is the first floor(div/2) steps. Assumes div >= 2 while running.
module sysref_divider
    import sysref_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         tick_i,
    input  logic [W-1:0] div_i,
    output logic         hi_o,
    output logic         wrap_o
);
    logic [W-1:0] phase;
    logic [W-1:0] half;

    assign half   = div_i >> 1;
    assign hi_o   = (phase < half);
    assign wrap_o = tick_i && (phase == div_i - 1'b1);

    // Purpose: phase counter with wrap at the divide value.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            phase <= '0;
        end else if (tick_i) begin
            phase <= wrap_o ? '0 : phase + 1'b1;
        end
    end

    AST_DIV_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (phase == '0)); // R3
endmodule

// File: rtl/sysref_sequencer.sv
// Mode sequencer: request edge detection, free-run state, burst control
// and the repeater pulse. Assumes en_ok already excludes reserved codes.
module sysref_sequencer
    import sysref_pkg::*;
#(
    parameter int PW = PLS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_ok_i,
    input  mode_e         mode_i,
    input  logic          req_i,
    input  logic [PW-1:0] pulses_i,
    input  logic          wrap_i,
    output logic          run_o,
    output logic          busy_o,
    output logic          rep_o,
    output logic          clear_o
);
    logic          req_q;
    logic          rise;
    logic          start;
    logic [PW-1:0] left;

    assign rise    = req_i && !req_q;
    assign start   = en_ok_i && (mode_i == MODE_BURST) && rise && !busy_o;
    assign clear_o = start || !(run_o || busy_o);

    // Purpose: request history, free-run flag and repeater pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            run_o <= 1'b0;
            rep_o <= 1'b0;
        end else begin
            req_q <= req_i;
            run_o <= en_ok_i && (mode_i == MODE_FREE);
            rep_o <= en_ok_i && (mode_i == MODE_REPEAT) && rise;
        end
    end

    // Purpose: burst state and remaining-period counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_ok_i || (mode_i != MODE_BURST)) begin
            busy_o <= 1'b0;
            left   <= '0;
        end else if (start) begin
            busy_o <= 1'b1;
            left   <= pulses_i;
        end else if (busy_o && wrap_i) begin
            if (left == PW'(1)) busy_o <= 1'b0;
            left <= left - 1'b1;
        end
    end

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy_o); // R5
    AST_BUSY_LEFT_NZ: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (left != '0)); // R5
    AST_BUSY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> $past(mode_i == MODE_BURST)); // R5
    AST_REP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rep_o |=> !rep_o); // R7
endmodule

// File: rtl/sysref_gen.sv
// SYSREF pulse generator top: decodes reserved codes, chains pre-divider,
// divider and sequencer, and forms the output. Assumes synchronised req_i.
module sysref_gen
    import sysref_pkg::*;
#(
    parameter int DW = DIV_W,
    parameter int PW = PLS_W,
    parameter int CW = PRE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_en,
    input  logic [1:0]    cfg_mode,
    input  logic [CW-1:0] cfg_prediv,
    input  logic [DW-1:0] cfg_div,
    input  logic [PW-1:0] cfg_pulses,
    input  logic          req_i,
    output logic          sysref_o,
    output logic          busy_o,
    output logic          cfg_err_o
);
    mode_e mode;
    logic  rsvd;
    logic  en_ok;
    logic  run, rep, clear, tick, hi, wrap;

    assign mode  = mode_e'(cfg_mode);
    assign rsvd  = (mode == MODE_RSVD) || (cfg_prediv == CW'(3)) ||
                   (cfg_div < DW'(2)) ||
                   ((mode == MODE_BURST) && (cfg_pulses == '0));
    assign en_ok = cfg_en && !rsvd;

    // Purpose: registered configuration error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err_o <= 1'b0;
        else        cfg_err_o <= cfg_en && rsvd;
    end

    sysref_sequencer #(.PW(PW)) i_seq (
        .clk(clk), .rst_n(rst_n), .en_ok_i(en_ok), .mode_i(mode),
        .req_i(req_i), .pulses_i(cfg_pulses), .wrap_i(wrap),
        .run_o(run), .busy_o(busy_o), .rep_o(rep), .clear_o(clear)
    );

    sysref_prediv #(.CODE_W(CW), .CNT_W(PCNT_W)) i_pre (
        .clk(clk), .rst_n(rst_n), .clear_i(clear), .adv_i(run || busy_o),
        .code_i(cfg_prediv), .tick_o(tick)
    );

    sysref_divider #(.W(DW)) i_div (
        .clk(clk), .rst_n(rst_n), .clear_i(clear), .tick_i(tick),
        .div_i(cfg_div), .hi_o(hi), .wrap_o(wrap)
    );

    assign sysref_o = ((run || busy_o) && hi) || rep;

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (!sysref_o && !busy_o)); // R9
    AST_ERR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (!sysref_o && !busy_o)); // R8
    AST_REP_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && mode == MODE_REPEAT) |=> !busy_o); // R7
endmodule

// File: tb/test_sysref_gen.sv
module test_sysref_gen;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic  o;
        logic  b;
        logic  e;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [1:0]  cfg_prediv = 2'd2;
    logic [11:0] cfg_div = 12'd5;
    logic [3:0]  cfg_pulses = 4'd1;
    logic        req_i = 1'b0;
    logic        sysref_o, busy_o, cfg_err_o;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sysref_gen i_sysref_gen (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
        .cfg_prediv(cfg_prediv), .cfg_div(cfg_div), .cfg_pulses(cfg_pulses),
        .req_i(req_i), .sysref_o(sysref_o), .busy_o(busy_o),
        .cfg_err_o(cfg_err_o)
    );

    // Reserved-code rule, from R8
    function automatic logic rsvd_now();
        return (cfg_mode == 2'd3) || (cfg_prediv == 2'd3) || (cfg_div < 12'd2) ||
               ((cfg_mode == 2'd1) && (cfg_pulses == 4'd0));
    endfunction

    // Driver: push the expectation for the state after the coming edge
    task automatic step(input logic eo, input logic eb, input string tag);
        exp_t it;
        it.o = eo; it.b = eb; it.e = cfg_en && rsvd_now(); it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    // Monitor: pop and compare after each rising edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            n_chk++;
            if (sysref_o !== it.o || busy_o !== it.b || cfg_err_o !== it.e) begin
                n_bad++;
                $display("FAIL %s: sysref=%0b exp=%0b busy=%0b exp=%0b err=%0b exp=%0b",
                         it.tag, sysref_o, it.o, busy_o, it.b, cfg_err_o, it.e);
            end
        end
    end

    task automatic go_idle(input string tag);
        cfg_en = 1'b0; req_i = 1'b0;
        step(1'b0, 1'b0, tag);
    endtask

    task automatic run_free(input int code, input int d, input int n, input string tag);
        int p, h;
        p = 1 << code; h = d / 2;
        cfg_mode = 2'd0; cfg_prediv = 2'(code); cfg_div = 12'(d); cfg_en = 1'b1;
        for (int t = 0; t < n; t++)
            step(((t % (d * p)) < h * p), 1'b0, tag);
    endtask

    task automatic run_burst(input int code, input int d, input int np,
                             input bit poke, input string tag);
        int p, h, len;
        p = 1 << code; h = d / 2; len = np * d * p;
        cfg_mode = 2'd1; cfg_prediv = 2'(code); cfg_div = 12'(d);
        cfg_pulses = 4'(np); cfg_en = 1'b1; req_i = 1'b0;
        step(1'b0, 1'b0, tag);
        step(1'b0, 1'b0, tag);
        req_i = 1'b1;
        for (int t = 0; t < len + 3; t++) begin
            if (poke && t == 1) req_i = 1'b0;
            if (poke && t == 3) req_i = 1'b1;   // R6 edge inside burst
            step((t < len) && ((t % (d * p)) < h * p), (t < len), tag);
        end
        req_i = 1'b0;
        step(1'b0, 1'b0, tag);
    endtask

    initial begin
        // R1 reset state
        step(1'b0, 1'b0, "R1");
        step(1'b0, 1'b0, "R1");
        rst_n = 1'b1;
        go_idle("R1");

        // R3 odd and even dividers, R2 step lengths
        run_free(0, 5, 20, "R3");
        go_idle("R9");
        run_free(2, 2, 24, "R2");
        go_idle("R9");
        run_free(1, 4, 24, "R2");
        go_idle("R9");
        run_free(0, 2, 8, "R4");
        go_idle("R9");
        run_free(0, 4095, 4100, "R4");
        go_idle("R9");

        // R9 restart from phase zero after re-enable
        run_free(0, 6, 9, "R9");
        go_idle("R9");
        run_free(0, 6, 8, "R9");
        go_idle("R9");

        // R5 bursts
        run_burst(0, 4, 3, 1'b0, "R5");
        run_burst(1, 3, 1, 1'b0, "R5");
        run_burst(0, 2, 15, 1'b0, "R5");
        go_idle("R9");
        // R6 edge during burst ignored
        run_burst(0, 4, 3, 1'b1, "R6");
        go_idle("R9");

        // R9 disable mid-burst
        cfg_mode = 2'd1; cfg_prediv = 2'd0; cfg_div = 12'd4; cfg_pulses = 4'd3;
        cfg_en = 1'b1; req_i = 1'b0;
        step(1'b0, 1'b0, "R9");
        req_i = 1'b1;
        step(1'b1, 1'b1, "R9");
        step(1'b1, 1'b1, "R9");
        step(1'b0, 1'b1, "R9");
        cfg_en = 1'b0;
        step(1'b0, 1'b0, "R9");
        step(1'b0, 1'b0, "R9");
        req_i = 1'b0;
        step(1'b0, 1'b0, "R9");

        // R7 repeater
        cfg_mode = 2'd2; cfg_div = 12'd5; cfg_en = 1'b1; req_i = 1'b0;
        step(1'b0, 1'b0, "R7");
        req_i = 1'b1;
        step(1'b1, 1'b0, "R7");
        step(1'b0, 1'b0, "R7");
        step(1'b0, 1'b0, "R7");
        req_i = 1'b0;
        step(1'b0, 1'b0, "R7");
        req_i = 1'b1;
        step(1'b1, 1'b0, "R7");
        req_i = 1'b0;
        step(1'b0, 1'b0, "R7");
        go_idle("R9");

        // R8 reserved codes
        cfg_en = 1'b1; cfg_mode = 2'd3;
        step(1'b0, 1'b0, "R8 mode3");
        step(1'b0, 1'b0, "R8 mode3");
        cfg_mode = 2'd0; cfg_prediv = 2'd3;
        step(1'b0, 1'b0, "R8 prediv3");
        cfg_prediv = 2'd0; cfg_div = 12'd1;
        step(1'b0, 1'b0, "R8 div1");
        cfg_div = 12'd0;
        step(1'b0, 1'b0, "R8 div0");
        cfg_div = 12'd4; cfg_mode = 2'd1; cfg_pulses = 4'd0;
        step(1'b0, 1'b0, "R8 pulses0");
        req_i = 1'b1;
        step(1'b0, 1'b0, "R8 pulses0 req");
        step(1'b0, 1'b0, "R8 pulses0 req");
        req_i = 1'b0;
        cfg_en = 1'b0; cfg_mode = 2'd3;
        step(1'b0, 1'b0, "R8 disabled");
        step(1'b0, 1'b0, "R8 disabled");

        @(posedge clk);
        #(CLK_PERIOD/2);
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: run did not complete, exp=done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule